// File: doc/BRIEF.md
# ID-Tagged Split-Transaction Bus Controller

This block sits between a processor and a set of memory targets. Reads and writes use separate channels for addresses and for data. Every command carries a 4-bit transaction tag. An accepted command is acknowledged in the same cycle and placed in a per-channel command queue. One credit-return pulse per dequeued entry lets the processor keep a credit counter. That counter starts at the queue depth and stops the processor from ever overrunning a queue. At the head of each queue, the upper address bits choose one of `NTGT` target stubs, and the lower bits address a word inside that target. Each stub answers after a fixed latency.

The read engine moves through the states IDLE, ISSUE, WAIT, ANNOUNCE and SEND:
- IDLE to ISSUE: it dequeues a command.
- ISSUE to WAIT: it sends the target request.
- WAIT to ANNOUNCE: the target returns data.
- ANNOUNCE: it shows the tag it holds data for and stays there until the processor grants.
- ANNOUNCE to SEND: on the grant.
- SEND to IDLE: it drives the full data word for one cycle.

The write engine moves through the states IDLE, FETCH, ISSUE, WAIT and DONE:
- IDLE to FETCH: it dequeues a command.
- FETCH: it asks the processor for the data of the current tag and ignores data carrying any other tag.
- FETCH to ISSUE: matching data arrives.
- ISSUE to WAIT: it writes to the target only after that, when address and data are both held.
- WAIT to DONE: the target acknowledges.
- DONE to IDLE: it reports completion for the tag.

A tag is live from its acknowledge until its data transfer (reads) or its completion (writes). A command reusing a live tag on the same channel is refused.

Top module: `idtag_bus_ctrl`

## Requirements
- R1: A read command is acknowledged (`ra_ack` high in the same cycle as `ra_valid`) exactly when the read queue is not full and its tag is not live on the read channel.
- R2: Each command queue holds `DEPTH` entries. `rd_credit_ret` / `wr_credit_ret` pulse once per dequeued entry. When a queue is full, further commands are not acknowledged, so a processor starting with `DEPTH` credits never overflows it and ends with `DEPTH` credits once idle.
- R3: Address bits [AW-1 : AW-log2(NTGT)] select the target, and the remaining low bits select the word inside it. The same low bits in two targets hold independent words.
- R4: After the target latency, `rd_avail` is raised with `rd_avail_id` equal to the command's tag. Both hold unchanged until `rd_grant` is sampled high, and the word follows on `rd_data_valid` in the next cycle, for exactly one cycle, with `rd_data_id` equal to the tag.
- R5: No read data is presented while the grant is withheld.
- R6: A write command is acknowledged (`wa_ack` in the same cycle as `wa_valid`) exactly when the write queue is not full and its tag is not live on the write channel.
- R7: In FETCH, `wd_req` is held high with `wd_req_id` equal to the current tag. A `wd_valid` whose `wd_id` differs is ignored and the request stays up.
- R8: The target write is issued only after matching data is taken. `wr_done` then pulses once with `wr_done_id` equal to the tag.
- R9: A read tag is live from acknowledge until its data cycle, and a write tag is live from acknowledge until `wr_done`. A command reusing a live tag on the same channel is refused.
- R10: A read returns the full `DW`-bit word last written to that address.
- R11: After reset, `rd_avail`, `rd_data_valid`, `wd_req`, `wr_done` and both credit-return pulses are low, and all tags are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_valid | input | 1 | Read command present |
| ra_id | input | IDW | Read command tag |
| ra_addr | input | AW | Read word address |
| ra_ack | output | 1 | Read command accepted this cycle |
| rd_credit_ret | output | 1 | One read-queue credit returned |
| rd_avail | output | 1 | Read data held for `rd_avail_id` |
| rd_avail_id | output | IDW | Tag whose data is held |
| rd_grant | input | 1 | Processor permits the held data transfer |
| rd_data_valid | output | 1 | Read data cycle |
| rd_data_id | output | IDW | Tag of the read data |
| rd_data | output | DW | Full read word |
| wa_valid | input | 1 | Write command present |
| wa_id | input | IDW | Write command tag |
| wa_addr | input | AW | Write word address |
| wa_ack | output | 1 | Write command accepted this cycle |
| wr_credit_ret | output | 1 | One write-queue credit returned |
| wd_req | output | 1 | Controller asks for write data |
| wd_req_id | output | IDW | Tag whose data is asked for |
| wd_valid | input | 1 | Write data present |
| wd_id | input | IDW | Tag of the write data |
| wd_data | input | DW | Write word |
| wr_done | output | 1 | Write completed |
| wr_done_id | output | IDW | Tag of completed write |

## Verification
The following properties are checked on every cycle:
- queue occupancy never passes its depth, and no queue is pushed when full or popped when empty;
- a held read announcement and a pending write-data request keep their tag until answered;
- data is presented only in the cycle after a grant;
- target writes happen only one cycle after matching data;
- every returned or completed tag is live.

Only the bench scenarios can show the rest: which commands are refused for a full queue or a live tag, the balance of credits, routing to separate targets, and that the words read back equal those written.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_ISSUE,
        RD_WAIT,
        RD_ANNOUNCE,
        RD_SEND
    } rd_state_t;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_FETCH,
        WR_ISSUE,
        WR_WAIT,
        WR_DONE
    } wr_state_t;

endpackage

// File: rtl/sbc_cmd_fifo.sv
`timescale 1ns/1ps
module sbc_cmd_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = slots[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R2
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/sbc_tgt_stub.sv
`timescale 1ns/1ps
module sbc_tgt_stub #(
    parameter int DW  = 32,
    parameter int LAW = 5,
    parameter int LAT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rreq,
    input  logic [LAW-1:0] raddr,
    output logic           rvalid,
    output logic [DW-1:0]  rdata,
    input  logic           wreq,
    input  logic [LAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    output logic           wack
);
    localparam int WORDS = 2 ** LAW;
    localparam int CW    = $clog2(LAT + 1);

    logic [DW-1:0] words [WORDS];
    logic [CW-1:0] rcnt, wcnt;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '0;
        end else if (wreq) begin
            words[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rreq) rdata_q <= words[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt <= '0;
            wcnt <= '0;
        end else begin
            if (rreq)              rcnt <= CW'(LAT);
            else if (rcnt != '0)   rcnt <= rcnt - 1'b1;
            if (wreq)              wcnt <= CW'(LAT);
            else if (wcnt != '0)   wcnt <= wcnt - 1'b1;
        end
    end

    assign rvalid = (rcnt == CW'(1));
    assign wack   = (wcnt == CW'(1));
    assign rdata  = rdata_q;

    // R10
    no_rd_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rreq |-> (rcnt == '0));
    // R8
    no_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wreq |-> (wcnt == '0));

endmodule

// File: rtl/sbc_rd_engine.sv
`timescale 1ns/1ps
module sbc_rd_engine
    import sbc_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 32,
    parameter int IDW  = 4,
    parameter int NTGT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      q_empty,
    input  logic [IDW-1:0]            q_id,
    input  logic [AW-1:0]             q_addr,
    output logic                      q_pop,
    output logic [NTGT-1:0]           tgt_rreq,
    output logic [AW-$clog2(NTGT)-1:0] tgt_raddr,
    input  logic [NTGT-1:0]           tgt_rvalid,
    input  logic [NTGT-1:0][DW-1:0]   tgt_rdata,
    output logic                      rd_avail,
    output logic [IDW-1:0]            rd_avail_id,
    input  logic                      rd_grant,
    output logic                      rd_data_valid,
    output logic [IDW-1:0]            rd_data_id,
    output logic [DW-1:0]             rd_data
);
    localparam int SELW = $clog2(NTGT);
    localparam int LAW  = AW - SELW;

    rd_state_t       st, nxt;
    logic [IDW-1:0]  cur_id;
    logic [AW-1:0]   cur_addr;
    logic [DW-1:0]   data_q;
    logic [SELW-1:0] sel;

    assign sel = cur_addr[AW-1 -: SELW];

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt           = st;
        q_pop         = 1'b0;
        tgt_rreq      = '0;
        rd_avail      = 1'b0;
        rd_data_valid = 1'b0;
        unique case (st)
            RD_IDLE: begin
                if (!q_empty) begin
                    q_pop = 1'b1;
                    nxt   = RD_ISSUE;
                end
            end
            RD_ISSUE: begin
                tgt_rreq[sel] = 1'b1;
                nxt           = RD_WAIT;
            end
            RD_WAIT: begin
                if (tgt_rvalid[sel]) nxt = RD_ANNOUNCE;
            end
            RD_ANNOUNCE: begin
                rd_avail = 1'b1;
                if (rd_grant) nxt = RD_SEND;
            end
            RD_SEND: begin
                rd_data_valid = 1'b1;
                nxt           = RD_IDLE;
            end
            default: nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id   <= '0;
            cur_addr <= '0;
            data_q   <= '0;
        end else begin
            if (q_pop) begin
                cur_id   <= q_id;
                cur_addr <= q_addr;
            end
            if (st == RD_WAIT && tgt_rvalid[sel]) data_q <= tgt_rdata[sel];
        end
    end

    assign tgt_raddr   = cur_addr[LAW-1:0];
    assign rd_avail_id = cur_id;
    assign rd_data_id  = cur_id;
    assign rd_data     = data_q;

    // R4
    avail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_avail && !rd_grant) |=> (rd_avail && $stable(rd_avail_id)));
    // R4
    grant_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_avail && rd_grant) |=> (rd_data_valid && !rd_avail));
    // R5
    data_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_valid |-> $past(rd_avail && rd_grant));
    // R4
    data_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_valid |=> !rd_data_valid);

endmodule

// File: rtl/sbc_wr_engine.sv
`timescale 1ns/1ps
module sbc_wr_engine
    import sbc_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 32,
    parameter int IDW  = 4,
    parameter int NTGT = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       q_empty,
    input  logic [IDW-1:0]             q_id,
    input  logic [AW-1:0]              q_addr,
    output logic                       q_pop,
    output logic                       wd_req,
    output logic [IDW-1:0]             wd_req_id,
    input  logic                       wd_valid,
    input  logic [IDW-1:0]             wd_id,
    input  logic [DW-1:0]              wd_data,
    output logic [NTGT-1:0]            tgt_wreq,
    output logic [AW-$clog2(NTGT)-1:0] tgt_waddr,
    output logic [DW-1:0]              tgt_wdata,
    input  logic [NTGT-1:0]            tgt_wack,
    output logic                       wr_done,
    output logic [IDW-1:0]             wr_done_id
);
    localparam int SELW = $clog2(NTGT);
    localparam int LAW  = AW - SELW;

    wr_state_t       st, nxt;
    logic [IDW-1:0]  cur_id;
    logic [AW-1:0]   cur_addr;
    logic [DW-1:0]   data_q;
    logic [SELW-1:0] sel;
    logic            take;

    assign sel  = cur_addr[AW-1 -: SELW];
    assign take = (st == WR_FETCH) && wd_valid && (wd_id == cur_id);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= WR_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = st;
        q_pop    = 1'b0;
        wd_req   = 1'b0;
        tgt_wreq = '0;
        wr_done  = 1'b0;
        unique case (st)
            WR_IDLE: begin
                if (!q_empty) begin
                    q_pop = 1'b1;
                    nxt   = WR_FETCH;
                end
            end
            WR_FETCH: begin
                wd_req = 1'b1;
                if (take) nxt = WR_ISSUE;
            end
            WR_ISSUE: begin
                tgt_wreq[sel] = 1'b1;
                nxt           = WR_WAIT;
            end
            WR_WAIT: begin
                if (tgt_wack[sel]) nxt = WR_DONE;
            end
            WR_DONE: begin
                wr_done = 1'b1;
                nxt     = WR_IDLE;
            end
            default: nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id   <= '0;
            cur_addr <= '0;
            data_q   <= '0;
        end else begin
            if (q_pop) begin
                cur_id   <= q_id;
                cur_addr <= q_addr;
            end
            if (take) data_q <= wd_data;
        end
    end

    assign wd_req_id  = cur_id;
    assign wr_done_id = cur_id;
    assign tgt_waddr  = cur_addr[LAW-1:0];
    assign tgt_wdata  = data_q;

    // R7
    wd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_req && !(wd_valid && wd_id == wd_req_id)) |=> (wd_req && $stable(wd_req_id)));
    // R8
    wr_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tgt_wreq) |-> $past(wd_req && wd_valid && wd_id == wd_req_id));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

endmodule

// File: rtl/idtag_bus_ctrl.sv
`timescale 1ns/1ps
module idtag_bus_ctrl #(
    parameter int AW      = 6,
    parameter int DW      = 32,
    parameter int IDW     = 4,
    parameter int DEPTH   = 4,
    parameter int NTGT    = 2,
    parameter int TGT_LAT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ra_valid,
    input  logic [IDW-1:0] ra_id,
    input  logic [AW-1:0]  ra_addr,
    output logic           ra_ack,
    output logic           rd_credit_ret,
    output logic           rd_avail,
    output logic [IDW-1:0] rd_avail_id,
    input  logic           rd_grant,
    output logic           rd_data_valid,
    output logic [IDW-1:0] rd_data_id,
    output logic [DW-1:0]  rd_data,
    input  logic           wa_valid,
    input  logic [IDW-1:0] wa_id,
    input  logic [AW-1:0]  wa_addr,
    output logic           wa_ack,
    output logic           wr_credit_ret,
    output logic           wd_req,
    output logic [IDW-1:0] wd_req_id,
    input  logic           wd_valid,
    input  logic [IDW-1:0] wd_id,
    input  logic [DW-1:0]  wd_data,
    output logic           wr_done,
    output logic [IDW-1:0] wr_done_id
);
    localparam int SELW = $clog2(NTGT);
    localparam int LAW  = AW - SELW;
    localparam int NID  = 2 ** IDW;
    localparam int CMDW = IDW + AW;

    logic [NID-1:0]  rd_live, wr_live;
    logic            rq_full, rq_empty, rq_pop;
    logic            wq_full, wq_empty, wq_pop;
    logic [CMDW-1:0] rq_head, wq_head;

    logic [NTGT-1:0]         t_rreq, t_rvalid, t_wreq, t_wack;
    logic [NTGT-1:0][DW-1:0] t_rdata;
    logic [LAW-1:0]          t_raddr, t_waddr;
    logic [DW-1:0]           t_wdata;

    assign ra_ack = ra_valid && !rq_full && !rd_live[ra_id];
    assign wa_ack = wa_valid && !wq_full && !wr_live[wa_id];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_live <= '0;
            wr_live <= '0;
        end else begin
            if (ra_ack)        rd_live[ra_id]      <= 1'b1;
            if (rd_data_valid) rd_live[rd_data_id] <= 1'b0;
            if (wa_ack)        wr_live[wa_id]      <= 1'b1;
            if (wr_done)       wr_live[wr_done_id] <= 1'b0;
        end
    end

    sbc_cmd_fifo #(.W(CMDW), .DEPTH(DEPTH)) u_rq (
        .clk(clk), .rst_n(rst_n), .push(ra_ack), .din({ra_id, ra_addr}),
        .pop(rq_pop), .head(rq_head), .full(rq_full), .empty(rq_empty));

    sbc_cmd_fifo #(.W(CMDW), .DEPTH(DEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n), .push(wa_ack), .din({wa_id, wa_addr}),
        .pop(wq_pop), .head(wq_head), .full(wq_full), .empty(wq_empty));

    assign rd_credit_ret = rq_pop;
    assign wr_credit_ret = wq_pop;

    sbc_rd_engine #(.AW(AW), .DW(DW), .IDW(IDW), .NTGT(NTGT)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .q_empty(rq_empty), .q_id(rq_head[CMDW-1 -: IDW]), .q_addr(rq_head[AW-1:0]),
        .q_pop(rq_pop),
        .tgt_rreq(t_rreq), .tgt_raddr(t_raddr), .tgt_rvalid(t_rvalid), .tgt_rdata(t_rdata),
        .rd_avail(rd_avail), .rd_avail_id(rd_avail_id), .rd_grant(rd_grant),
        .rd_data_valid(rd_data_valid), .rd_data_id(rd_data_id), .rd_data(rd_data));

    sbc_wr_engine #(.AW(AW), .DW(DW), .IDW(IDW), .NTGT(NTGT)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .q_empty(wq_empty), .q_id(wq_head[CMDW-1 -: IDW]), .q_addr(wq_head[AW-1:0]),
        .q_pop(wq_pop),
        .wd_req(wd_req), .wd_req_id(wd_req_id), .wd_valid(wd_valid), .wd_id(wd_id),
        .wd_data(wd_data),
        .tgt_wreq(t_wreq), .tgt_waddr(t_waddr), .tgt_wdata(t_wdata), .tgt_wack(t_wack),
        .wr_done(wr_done), .wr_done_id(wr_done_id));

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        sbc_tgt_stub #(.DW(DW), .LAW(LAW), .LAT(TGT_LAT)) u_stub (
            .clk(clk), .rst_n(rst_n),
            .rreq(t_rreq[t]), .raddr(t_raddr), .rvalid(t_rvalid[t]), .rdata(t_rdata[t]),
            .wreq(t_wreq[t]), .waddr(t_waddr), .wdata(t_wdata), .wack(t_wack[t]));
    end

    // R9
    rd_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_valid |-> rd_live[rd_data_id]);
    // R9
    wr_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> wr_live[wr_done_id]);
    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(t_rreq) && $onehot0(t_wreq));

endmodule

// File: tb/idtag_bus_ctrl_test.sv
`timescale 1ns/1ps
module idtag_bus_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int NVEC  = 6;
    // {addr[5:0], id[3:0], data[31:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {6'h03, 4'h1, 32'hA5A5_0001},
        {6'h23, 4'h2, 32'h5A5A_0002},
        {6'h1F, 4'h3, 32'hFFFF_FFFF},
        {6'h3F, 4'h4, 32'h8000_0001},
        {6'h10, 4'h5, 32'h1234_5678},
        {6'h30, 4'h6, 32'hDEAD_BEEF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ra_valid = 1'b0, rd_grant = 1'b0, wa_valid = 1'b0, wd_valid = 1'b0;
    logic [3:0] ra_id = '0, wa_id = '0, wd_id = '0;
    logic [5:0] ra_addr = '0, wa_addr = '0;
    logic [31:0] wd_data = '0;
    logic ra_ack, rd_credit_ret, rd_avail, rd_data_valid, wa_ack, wr_credit_ret, wd_req, wr_done;
    logic [3:0] rd_avail_id, rd_data_id, wd_req_id, wr_done_id;
    logic [31:0] rd_data;

    int checks = 0, errors = 0, rcred = DEPTH, wcred = DEPTH;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idtag_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ra_valid(ra_valid), .ra_id(ra_id), .ra_addr(ra_addr), .ra_ack(ra_ack),
        .rd_credit_ret(rd_credit_ret), .rd_avail(rd_avail), .rd_avail_id(rd_avail_id),
        .rd_grant(rd_grant), .rd_data_valid(rd_data_valid), .rd_data_id(rd_data_id),
        .rd_data(rd_data),
        .wa_valid(wa_valid), .wa_id(wa_id), .wa_addr(wa_addr), .wa_ack(wa_ack),
        .wr_credit_ret(wr_credit_ret), .wd_req(wd_req), .wd_req_id(wd_req_id),
        .wd_valid(wd_valid), .wd_id(wd_id), .wd_data(wd_data),
        .wr_done(wr_done), .wr_done_id(wr_done_id));

    always @(posedge clk) begin
        if (!rst_n) begin
            rcred <= DEPTH;
            wcred <= DEPTH;
        end else begin
            rcred <= rcred - int'(ra_ack) + int'(rd_credit_ret);
            wcred <= wcred - int'(wa_ack) + int'(wr_credit_ret);
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_ra(input logic [3:0] id, input logic [5:0] a, output logic acked);
        @(negedge clk);
        ra_valid = 1'b1; ra_id = id; ra_addr = a;
        #1 acked = ra_ack;
        @(posedge clk);
        #1 ra_valid = 1'b0;
    endtask

    task automatic send_wa(input logic [3:0] id, input logic [5:0] a, output logic acked);
        @(negedge clk);
        wa_valid = 1'b1; wa_id = id; wa_addr = a;
        #1 acked = wa_ack;
        @(posedge clk);
        #1 wa_valid = 1'b0;
    endtask

    task automatic wait_avail();
        int n = 0;
        @(negedge clk);
        while (!rd_avail && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic wait_wdreq();
        int n = 0;
        @(negedge clk);
        while (!wd_req && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while (!wr_done && n < 100) begin @(negedge clk); n++; end
    endtask

    // grant the announced read and check the data cycle (at a negedge on entry)
    task automatic grant_and_check(input logic [3:0] id, input logic [31:0] exp);
        chk("R4 announced tag", 64'(rd_avail_id), 64'(id));
        rd_grant = 1'b1;
        @(negedge clk);
        rd_grant = 1'b0;
        chk("R4 data valid after grant", 64'(rd_data_valid), 64'd1);
        chk("R4 data tag", 64'(rd_data_id), 64'(id));
        chk("R10 full word", 64'(rd_data), 64'(exp));
        @(negedge clk);
        chk("R4 single data cycle", 64'(rd_data_valid), 64'd0);
    endtask

    task automatic do_write(input logic [3:0] id, input logic [5:0] a, input logic [31:0] d,
                            input bit wrong_first);
        logic ok;
        send_wa(id, a, ok);
        chk("R6 write accepted", 64'(ok), 64'd1);
        wait_wdreq();
        chk("R7 data request tag", 64'(wd_req_id), 64'(id));
        if (wrong_first) begin
            wd_valid = 1'b1; wd_id = id ^ 4'h1; wd_data = ~d;
            @(negedge clk);
            wd_valid = 1'b0;
            chk("R7 wrong tag ignored", {63'd0, wd_req}, 64'd1);
            chk("R7 request tag held", 64'(wd_req_id), 64'(id));
        end
        wd_valid = 1'b1; wd_id = id; wd_data = d;
        @(negedge clk);
        wd_valid = 1'b0;
        chk("R7 request dropped after data", 64'(wd_req), 64'd0);
        wait_done();
        chk("R8 done tag", {59'd0, wr_done, wr_done_id}, {59'd0, 1'b1, id});
    endtask

    task automatic do_read(input logic [3:0] id, input logic [5:0] a, input logic [31:0] d,
                           input int hold);
        logic ok;
        send_ra(id, a, ok);
        chk("R1 read accepted", 64'(ok), 64'd1);
        wait_avail();
        for (int k = 0; k < hold; k++) begin
            chk("R5 no data without grant", 64'(rd_data_valid), 64'd0);
            chk("R4 announce held", 64'(rd_avail), 64'd1);
            @(negedge clk);
        end
        grant_and_check(id, d);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rd_avail low", 64'(rd_avail), 64'd0);
        chk("R11 rd_data_valid low", 64'(rd_data_valid), 64'd0);
        chk("R11 wd_req low", 64'(wd_req), 64'd0);
        chk("R11 wr_done low", 64'(wr_done), 64'd0);
        chk("R11 credit pulses low", {62'd0, rd_credit_ret, wr_credit_ret}, 64'd0);

        // table walk: write each vector, then read each back (R3, R10)
        for (int i = 0; i < NVEC; i++)
            do_write(VEC[i][35:32], VEC[i][41:36], VEC[i][31:0], i == 1);
        for (int i = 0; i < NVEC; i++)
            do_read(VEC[i][35:32], VEC[i][41:36], VEC[i][31:0], (i == 2) ? 5 : 0);
        repeat (3) @(negedge clk);
        chk("R2 read credits restored", 64'(rcred), 64'(DEPTH));
        chk("R2 write credits restored", 64'(wcred), 64'(DEPTH));

        // R9 write tag reuse refused while live
        send_wa(4'h9, 6'h05, ok);
        chk("R6 write accepted", 64'(ok), 64'd1);
        wait_wdreq();
        send_wa(4'h9, 6'h06, ok);
        chk("R9 live write tag refused", 64'(ok), 64'd0);
        @(negedge clk);
        wd_valid = 1'b1; wd_id = 4'h9; wd_data = 32'h0BAD_F00D;
        @(negedge clk);
        wd_valid = 1'b0;
        wait_done();
        chk("R8 done tag", 64'(wr_done_id), 64'h9);
        do_read(4'hA, 6'h05, 32'h0BAD_F00D, 0);

        // R9 read tag reuse and R2 full queue
        send_ra(4'h8, 6'h03, ok);
        chk("R1 read accepted", 64'(ok), 64'd1);
        wait_avail();
        send_ra(4'h8, 6'h03, ok);
        chk("R9 live read tag refused", 64'(ok), 64'd0);
        for (int k = 9; k <= 12; k++) begin
            send_ra(4'(k), 6'h23, ok);
            chk("R2 fill accepted", 64'(ok), 64'd1);
        end
        send_ra(4'hD, 6'h23, ok);
        chk("R2 full queue refused", 64'(ok), 64'd0);
        chk("R2 no credits left", 64'(rcred), 64'd0);
        @(negedge clk);
        grant_and_check(4'h8, 32'hA5A5_0001);
        for (int k = 9; k <= 12; k++) begin
            wait_avail();
            grant_and_check(4'(k), 32'h5A5A_0002);
        end
        repeat (3) @(negedge clk);
        chk("R2 credits back to depth", 64'(rcred), 64'(DEPTH));
        // freed tag reusable
        do_read(4'h8, 6'h3F, 32'h8000_0001, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule